// File: doc/BRIEF.md
# Multi-mode DUT trigger interface

This block fans one trigger event out to four attached devices under test, each of which may speak a different handshake protocol. A trigger pulse arrives together with a 32-bit event number. Every device channel decides, from its own two-bit field of a run-time mode word, how to deliver it. The handshake mode asserts trigger and waits for the device to answer with busy; the device can then pull the event number out on its own readout clock. The two synchronous modes drive a clock to the device and send a one-period trigger. One of them follows the trigger with the event number, one bit per device clock, most significant bit first. The other sends the trigger alone.

A device reset/sync request is forwarded to every channel. In the synchronous modes the reset and the trigger are released by identical register paths, so both keep the same phase to the device clock. A synchronous clear input empties every serialiser and output register without touching the asynchronous reset. All device-facing outputs leave through one final register stage.

Top module: `dut_trig_if`

## Requirements
- R1: Device n takes its mode from mode_i[2n+1:2n]: 00 handshake, 01 synchronous with event number, 11 synchronous without event number. The reserved value 10 behaves exactly like 11.
- R2: Handshake mode: an accepted trigger raises trig_o, which stays high until the synchronised busy_i is seen high and then falls. dclk_o stays low for a channel in handshake.
- R3: Handshake mode: trig_i is ignored while the synchronised busy_i is high, and while a handshake is still open (trigger not yet answered, or busy not yet released).
- R4: Handshake mode: data_o presents the most significant bit of the event number captured at acceptance. It advances by one bit, MSB first, on each rising edge of rdclk_i after a two-flop synchroniser.
- R5: In the synchronous modes dclk_o toggles on every clock, giving a period of two clocks. trig_o, rst_o and data_o change only in the cycle where dclk_o falls, so the device samples them on its rising edge.
- R6: Mode 01: after acceptance, trig_o is high for exactly one device-clock period. The next 32 periods carry the event number on data_o, MSB first, and data_o then returns low.
- R7: Mode 11 (and 10): trig_o is high for exactly one device-clock period, and data_o stays low throughout.
- R8: A dev_rst_i pulse gives rst_o high for one device-clock period in the synchronous modes. It starts in the same period as the trigger when both are requested in the same cycle. In handshake mode, rst_o repeats dev_rst_i two clocks later.
- R9: Synchronous modes: trig_i is ignored while the channel has a trigger pending or is still sending; the event number is the one present in the accepting cycle.
- R10: A cycle with sif_clr_i high drives all outputs low on the next clock and abandons every pending trigger, open handshake and serialisation.
- R11: While rst_ni is low all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sif_clr_i | input | 1 | Synchronous clear of channels and output stage |
| trig_i | input | 1 | Trigger request, one cycle per event |
| trig_num_i | input | NUM_W | Event number, valid with trig_i |
| dev_rst_i | input | 1 | Device reset/sync request |
| mode_i | input | 2*NDEV | Per-device mode fields, two bits each |
| busy_i | input | NDEV | Per-device busy, asynchronous |
| rdclk_i | input | NDEV | Per-device readout clock, asynchronous |
| trig_o | output | NDEV | Per-device trigger |
| rst_o | output | NDEV | Per-device reset/sync |
| data_o | output | NDEV | Per-device event-number data |
| dclk_o | output | NDEV | Per-device clock sent in synchronous modes |

## Verification
The trigger and the reset/sync request can fall in the same cycle. In the synchronous channels they must come out in the same device-clock period, because each waits for the same release tick. The bench drives dev_rst_i in the same cycle as trig_i on one event. At the device clock rising edge where the trigger is sampled, the synchronous device models require rst_o to be high as well. A separate reset-only pulse must give exactly one period of rst_o and no trigger.

// File: rtl/dti_pkg.sv
`timescale 1ns/1ps
package dti_pkg;
  typedef enum logic [1:0] {
    MD_HS      = 2'b00,
    MD_SYN_NUM = 2'b01,
    MD_RSV     = 2'b10,
    MD_SYN     = 2'b11
  } dti_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HS_ASSERT,
    ST_HS_WAIT,
    ST_SY_PEND,
    ST_SY_TRIG,
    ST_SY_SHIFT
  } dti_state_e;

  function automatic logic mode_is_hs(input logic [1:0] m);
    return m == MD_HS;
  endfunction

  // reserved code falls through to the no-number synchronous mode
  function automatic logic mode_has_num(input logic [1:0] m);
    return m == MD_SYN_NUM;
  endfunction
endpackage

// File: rtl/dti_sync.sv
`timescale 1ns/1ps
module dti_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned W      = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg <= '0;
    end else begin
      stg[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/dti_phase.sv
`timescale 1ns/1ps
module dti_phase (
  input  logic clk_i,
  input  logic rst_ni,
  output logic ph_o
);
  logic ph;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph <= 1'b0;
    else         ph <= ~ph;
  end

  assign ph_o = ph;
endmodule

// File: rtl/dti_chan.sv
`timescale 1ns/1ps
module dti_chan
  import dti_pkg::*;
#(
  parameter int unsigned NUM_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             tick_i,     // device clock about to fall
  input  logic [1:0]       mode_i,
  input  logic             trig_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic             dev_rst_i,
  input  logic             busy_s_i,
  input  logic             rd_s_i,
  output logic             trig_o,
  output logic             rst_o,
  output logic             data_o,
  output logic             hs_act_o,
  output logic             sync_en_o
);
  localparam int unsigned CNT_W = (NUM_W > 1) ? $clog2(NUM_W) : 1;
  localparam int unsigned MSB   = NUM_W - 1;

  dti_state_e       state;
  logic [NUM_W-1:0] sr;
  logic [CNT_W-1:0] cnt;
  logic             with_num;
  logic             trig_q, rst_q, data_q, rst_pend, rd_q;
  logic             rd_rise, sy_act, hs_act, sync_en;

  assign rd_rise = rd_s_i & ~rd_q;
  assign hs_act  = (state == ST_HS_ASSERT) || (state == ST_HS_WAIT);
  assign sy_act  = (state == ST_SY_PEND) || (state == ST_SY_TRIG) ||
                   (state == ST_SY_SHIFT);
  assign sync_en = sy_act || ((state == ST_IDLE) && !mode_is_hs(mode_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state    <= ST_IDLE;
      sr       <= '0;
      cnt      <= '0;
      with_num <= 1'b0;
      trig_q   <= 1'b0;
      rst_q    <= 1'b0;
      data_q   <= 1'b0;
      rst_pend <= 1'b0;
      rd_q     <= 1'b0;
    end else if (clr_i) begin
      state    <= ST_IDLE;
      sr       <= '0;
      cnt      <= '0;
      with_num <= 1'b0;
      trig_q   <= 1'b0;
      rst_q    <= 1'b0;
      data_q   <= 1'b0;
      rst_pend <= 1'b0;
      rd_q     <= rd_s_i;
    end else begin
      rd_q <= rd_s_i;

      // reset/sync path: same release tick as the trigger when synchronous
      if (sync_en) begin
        if (tick_i) begin
          rst_q    <= rst_pend;
          rst_pend <= dev_rst_i;
        end else begin
          rst_pend <= rst_pend | dev_rst_i;
        end
      end else begin
        rst_q    <= dev_rst_i;
        rst_pend <= 1'b0;
      end

      unique case (state)
        ST_IDLE: begin
          trig_q <= 1'b0;
          data_q <= 1'b0;
          if (trig_i) begin
            if (mode_is_hs(mode_i)) begin
              if (!busy_s_i) begin
                sr     <= num_i;
                trig_q <= 1'b1;
                state  <= ST_HS_ASSERT;
              end
            end else begin
              sr       <= num_i;
              with_num <= mode_has_num(mode_i);
              state    <= ST_SY_PEND;
            end
          end
        end
        ST_HS_ASSERT, ST_HS_WAIT: begin
          data_q <= sr[MSB];
          if (rd_rise) sr <= sr << 1;
          if (state == ST_HS_ASSERT) begin
            if (busy_s_i) begin
              trig_q <= 1'b0;
              state  <= ST_HS_WAIT;
            end
          end else if (!busy_s_i) begin
            state <= ST_IDLE;
          end
        end
        ST_SY_PEND: begin
          if (tick_i) begin
            trig_q <= 1'b1;
            state  <= ST_SY_TRIG;
          end
        end
        ST_SY_TRIG: begin
          if (tick_i) begin
            trig_q <= 1'b0;
            if (with_num) begin
              data_q <= sr[MSB];
              sr     <= sr << 1;
              cnt    <= CNT_W'(NUM_W - 1);
              state  <= ST_SY_SHIFT;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_SY_SHIFT: begin
          if (tick_i) begin
            if (cnt == '0) begin
              data_q <= 1'b0;
              state  <= ST_IDLE;
            end else begin
              data_q <= sr[MSB];
              sr     <= sr << 1;
              cnt    <= cnt - 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign trig_o    = trig_q;
  assign rst_o     = rst_q;
  assign data_o    = data_q;
  assign hs_act_o  = hs_act;
  assign sync_en_o = sync_en;
endmodule

// File: rtl/dti_outstage.sv
`timescale 1ns/1ps
module dti_outstage #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [W-1:0] trig_i,
  input  logic [W-1:0] rst_i,
  input  logic [W-1:0] data_i,
  input  logic [W-1:0] dclk_i,
  output logic [W-1:0] trig_o,
  output logic [W-1:0] rst_o,
  output logic [W-1:0] data_o,
  output logic [W-1:0] dclk_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_o <= '0;
      rst_o  <= '0;
      data_o <= '0;
      dclk_o <= '0;
    end else if (clr_i) begin
      trig_o <= '0;
      rst_o  <= '0;
      data_o <= '0;
      dclk_o <= '0;
    end else begin
      trig_o <= trig_i;
      rst_o  <= rst_i;
      data_o <= data_i;
      dclk_o <= dclk_i;
    end
  end
endmodule

// File: rtl/dut_trig_if.sv
`timescale 1ns/1ps
module dut_trig_if #(
  parameter int unsigned NDEV        = 4,
  parameter int unsigned NUM_W       = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sif_clr_i,
  input  logic                trig_i,
  input  logic [NUM_W-1:0]    trig_num_i,
  input  logic                dev_rst_i,
  input  logic [2*NDEV-1:0]   mode_i,
  input  logic [NDEV-1:0]     busy_i,
  input  logic [NDEV-1:0]     rdclk_i,
  output logic [NDEV-1:0]     trig_o,
  output logic [NDEV-1:0]     rst_o,
  output logic [NDEV-1:0]     data_o,
  output logic [NDEV-1:0]     dclk_o
);
  logic            ph;
  logic [NDEV-1:0] busy_s, rd_s;
  logic [NDEV-1:0] trig_c, rst_c, data_c, dclk_c, hs_act, sync_en;

  dti_phase u_phase (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ph_o  (ph)
  );

  dti_sync #(.STAGES(SYNC_STAGES), .W(NDEV)) u_busy_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (busy_i),
    .q_o   (busy_s)
  );

  dti_sync #(.STAGES(SYNC_STAGES), .W(NDEV)) u_rd_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rdclk_i),
    .q_o   (rd_s)
  );

  for (genvar d = 0; d < NDEV; d++) begin : g_ch
    dti_chan #(.NUM_W(NUM_W)) u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clr_i    (sif_clr_i),
      .tick_i   (ph),
      .mode_i   (mode_i[2*d +: 2]),
      .trig_i   (trig_i),
      .num_i    (trig_num_i),
      .dev_rst_i(dev_rst_i),
      .busy_s_i (busy_s[d]),
      .rd_s_i   (rd_s[d]),
      .trig_o   (trig_c[d]),
      .rst_o    (rst_c[d]),
      .data_o   (data_c[d]),
      .hs_act_o (hs_act[d]),
      .sync_en_o(sync_en[d])
    );
    assign dclk_c[d] = sync_en[d] & ph;
  end

  dti_outstage #(.W(NDEV)) u_out (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (sif_clr_i),
    .trig_i(trig_c),
    .rst_i (rst_c),
    .data_i(data_c),
    .dclk_i(dclk_c),
    .trig_o(trig_o),
    .rst_o (rst_o),
    .data_o(data_o),
    .dclk_o(dclk_o)
  );
endmodule

// File: rtl/dut_trig_if_chk.sv
`timescale 1ns/1ps
module dut_trig_if_chk #(
  parameter int unsigned NDEV = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            sif_clr_i,
  input logic [NDEV-1:0] trig_o,
  input logic [NDEV-1:0] rst_o,
  input logic [NDEV-1:0] data_o,
  input logic [NDEV-1:0] dclk_o,
  input logic [NDEV-1:0] busy_s,
  input logic [NDEV-1:0] hs_act
);
  p_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sif_clr_i |=> (trig_o == '0 && rst_o == '0 && data_o == '0 && dclk_o == '0));

  for (genvar d = 0; d < NDEV; d++) begin : g_dev
    p_trig_on_fall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (trig_o[d] != $past(trig_o[d])) |-> !dclk_o[d]);

    p_no_trig_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(trig_o[d]) && $past(hs_act[d])) |-> !$past(busy_s[d], 2));

    p_hs_clk_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(hs_act[d]) |-> !dclk_o[d]);
  end
endmodule

bind dut_trig_if dut_trig_if_chk #(.NDEV(NDEV)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sif_clr_i(sif_clr_i),
  .trig_o   (trig_o),
  .rst_o    (rst_o),
  .data_o   (data_o),
  .dclk_o   (dclk_o),
  .busy_s   (busy_s),
  .hs_act   (hs_act)
);

// File: tb/dut_trig_if_tb_top.sv
`timescale 1ns/1ps
module dut_trig_if_tb_top;
  localparam int NDEV = 4;
  localparam int NUM_W = 32;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sif_clr_i = 1'b0;
  logic trig_i = 1'b0;
  logic [NUM_W-1:0] trig_num_i = '0;
  logic dev_rst_i = 1'b0;
  logic [2*NDEV-1:0] mode_i = 8'h93; // dev0=11 dev1=00 dev2=01 dev3=10
  logic [NDEV-1:0] busy_m = '0, busy_f = '0, rdclk_m = '0;
  logic [NDEV-1:0] busy_i, rdclk_i;
  logic [NDEV-1:0] trig_o, rst_o, data_o, dclk_o;

  assign busy_i  = busy_m | busy_f;
  assign rdclk_i = rdclk_m;

  always #2.5 clk = ~clk;

  dut_trig_if #(.NDEV(NDEV), .NUM_W(NUM_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .sif_clr_i(sif_clr_i), .trig_i(trig_i),
    .trig_num_i(trig_num_i), .dev_rst_i(dev_rst_i), .mode_i(mode_i),
    .busy_i(busy_i), .rdclk_i(rdclk_i), .trig_o(trig_o), .rst_o(rst_o),
    .data_o(data_o), .dclk_o(dclk_o)
  );

  int total = 0, bad = 0;
  bit done = 1'b0, mon_en = 1'b1, exp_rst = 1'b0;
  logic [NUM_W-1:0] q_hs[$], q_sy[$];
  int fires = 0, seen_hs = 0, seen_sy = 0, seen_nn0 = 0, seen_nn3 = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=0x%0h exp=0x%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_rise(input int d);
    logic p;
    p = dclk_o[d];
    forever begin
      @(negedge clk);
      if (dclk_o[d] && !p) break;
      p = dclk_o[d];
    end
  endtask

  // driver: trig_i held two cycles, second cycle carries a different number
  task automatic fire(input logic [NUM_W-1:0] n, input bit with_rst, input bit push);
    @(negedge clk);
    trig_i = 1'b1; trig_num_i = n; dev_rst_i = with_rst;
    if (push) begin
      q_hs.push_back(n); q_sy.push_back(n); fires++; exp_rst = with_rst;
    end
    @(negedge clk);
    trig_num_i = ~n; dev_rst_i = 1'b0;
    @(negedge clk);
    trig_i = 1'b0;
  endtask

  // handshake device (dev1)
  task automatic hs_mon();
    logic [NUM_W-1:0] v, e;
    forever begin
      @(negedge clk);
      if (mon_en && trig_o[1]) begin
        repeat (3) @(negedge clk);
        chk(trig_o[1] == 1'b1, "R2 trig held until busy", trig_o[1], 1);
        busy_m[1] = 1'b1;
        repeat (8) @(negedge clk);
        chk(trig_o[1] == 1'b0, "R2 trig falls after busy", trig_o[1], 0);
        v = '0;
        for (int k = 0; k < NUM_W; k++) begin
          repeat (6) @(negedge clk);
          v = {v[NUM_W-2:0], data_o[1]};
          rdclk_m[1] = 1'b1;
          repeat (6) @(negedge clk);
          rdclk_m[1] = 1'b0;
        end
        e = (q_hs.size() > 0) ? q_hs.pop_front() : ~v;
        chk(v == e, "R4 handshake readout", v, e);
        busy_m[1] = 1'b0;
        repeat (8) @(negedge clk);
        seen_hs++;
      end
    end
  endtask

  // synchronous device with number (dev2)
  task automatic sy_mon();
    logic [NUM_W-1:0] v, e;
    forever begin
      wait_rise(2);
      if (mon_en && trig_o[2]) begin
        chk(rst_o[2] == exp_rst, "R8 rst with trig mode01", rst_o[2], exp_rst);
        v = '0;
        for (int k = 0; k < NUM_W; k++) begin
          wait_rise(2);
          if (trig_o[2]) chk(1'b0, "R6 trig one period", trig_o[2], 0);
          v = {v[NUM_W-2:0], data_o[2]};
        end
        wait_rise(2);
        chk(data_o[2] == 1'b0, "R6 data low after frame", data_o[2], 0);
        e = (q_sy.size() > 0) ? q_sy.pop_front() : ~v;
        chk(v == e, "R6 serial number MSB first", v, e);
        seen_sy++;
      end
    end
  endtask

  // synchronous devices without number (dev0 mode 11, dev3 mode 10)
  task automatic nn_mon(input int d);
    int errs;
    forever begin
      wait_rise(d);
      if (mon_en && trig_o[d]) begin
        chk(rst_o[d] == exp_rst, (d == 0) ? "R8 rst with trig mode11" : "R8 rst with trig mode10",
            rst_o[d], exp_rst);
        errs = 0;
        for (int k = 0; k < NUM_W + 2; k++) begin
          wait_rise(d);
          if (trig_o[d] || data_o[d]) errs++;
        end
        chk(errs == 0, (d == 0) ? "R7 no number mode11" : "R1 reserved acts as 11",
            errs, 0);
        if (d == 0) seen_nn0++; else seen_nn3++;
      end
    end
  endtask

  initial begin
    fork
      hs_mon();
      sy_mon();
      nn_mon(0);
      nn_mon(3);
    join_none
  end

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired act=0 exp=1");
      summary();
      $finish;
    end
  end

  initial begin
    int c0, c1, c3, errs;
    logic p;
    repeat (4) @(negedge clk);
    chk({trig_o, rst_o, data_o, dclk_o} == '0, "R11 outputs in reset",
        {trig_o, rst_o, data_o, dclk_o}, 0);
    rst_ni = 1'b1;
    repeat (10) @(negedge clk);
    chk({trig_o, rst_o, data_o} == '0, "R11 idle after reset", {trig_o, rst_o, data_o}, 0);

    // R5 device clock alternates; R2 handshake device gets no clock
    p = dclk_o[2]; errs = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (dclk_o[2] == p) errs++;
      if (dclk_o[1]) errs++;
      p = dclk_o[2];
    end
    chk(errs == 0, "R5 dclk toggles, R2 quiet in handshake", errs, 0);

    fire(32'hA5C3_0F81, 1'b0, 1'b1); repeat (700) @(negedge clk);
    fire(32'h1234_5678, 1'b1, 1'b1); repeat (700) @(negedge clk);
    exp_rst = 1'b0;
    fire(32'h8000_0001, 1'b0, 1'b1); repeat (700) @(negedge clk);
    fire(32'hFFFF_FFFF, 1'b0, 1'b1); repeat (700) @(negedge clk);
    fire(32'h0000_0000, 1'b0, 1'b1); repeat (700) @(negedge clk);

    // R3 R9: one delivery per event despite the extra trigger cycle
    chk(seen_hs == fires, "R3 handshake deliveries", seen_hs, fires);
    chk(seen_sy == fires, "R9 mode01 deliveries", seen_sy, fires);
    chk(seen_nn0 == fires, "R9 mode11 deliveries", seen_nn0, fires);
    chk(seen_nn3 == fires, "R1 mode10 deliveries", seen_nn3, fires);
    chk(q_hs.size() == 0 && q_sy.size() == 0, "R4 scoreboard drained",
        q_hs.size() + q_sy.size(), 0);

    // R8 reset-only pulse
    @(negedge clk); dev_rst_i = 1'b1;
    @(negedge clk); dev_rst_i = 1'b0;
    c0 = 0; c1 = 0; c3 = 0; errs = 0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      c0 += rst_o[0]; c1 += rst_o[1]; c3 += rst_o[3];
      if (trig_o != '0) errs++;
    end
    chk(c0 == 2, "R8 rst one period mode11", c0, 2);
    chk(c3 == 2, "R8 rst one period mode10", c3, 2);
    chk(c1 == 1, "R8 rst follows in handshake", c1, 1);
    chk(errs == 0, "R8 no trigger on reset", errs, 0);

    // R10 clear in the middle of activity
    mon_en = 1'b0;
    fire(32'hDEAD_BEEF, 1'b0, 1'b0);
    repeat (20) @(negedge clk);
    chk(trig_o[1] == 1'b1, "R2 handshake waiting for busy", trig_o[1], 1);
    sif_clr_i = 1'b1;
    @(negedge clk);
    sif_clr_i = 1'b0;
    chk({trig_o, rst_o, data_o, dclk_o} == '0, "R10 outputs cleared",
        {trig_o, rst_o, data_o, dclk_o}, 0);
    errs = 0;
    for (int k = 0; k < 150; k++) begin
      @(negedge clk);
      if (trig_o != '0 || data_o != '0) errs++;
    end
    chk(errs == 0, "R10 activity abandoned", errs, 0);

    // R3 busy high in idle blocks the handshake trigger
    busy_f[1] = 1'b1;
    repeat (6) @(negedge clk);
    fire(32'h0F0F_0F0F, 1'b0, 1'b0);
    errs = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (trig_o[1]) errs++;
    end
    chk(errs == 0, "R3 trigger blocked by busy", errs, 0);
    busy_f[1] = 1'b0;

    done = 1'b1;
    summary();
    $finish;
  end
endmodule